// File: doc/BRIEF.md
# Demand-Driven Packet Dispatcher

This block is the central controller of one node in a reduction network. It takes packets one at a time from an input queue and sorts them into two kinds. Packets that are only passing through go straight to the output. Packets this node must act on start a search: a load packet, a request packet or a result packet. For those, the block uses the program object memory, the store of waiting results and the output queue. Each of these three is reached through a valid/ready request channel. The program memory also returns its answer on a separate response channel.

A request that finds a value is answered at once with a result packet. A request that finds an expression that is not yet reduced does two things. It parks a waiting result entry in the waiting store. Then, if nobody has asked for that expression before, it sends out one new request for each identifier the expression refers to. A search that misses, and a load that collides, leave through one of four output sub-queues. The sub-queue is picked by a local hash of the object name and its context.

Top module: `reduce_dispatch`

## Requirements
- R1: After reset, in_ready is 1 and out_valid, pm_req_valid and ws_valid are all 0.
- R2: A packet with in_transit=1, or a packet of type code 3 (reserved), goes to the output unchanged (same type, name, context and payload). It makes no program memory access and writes no waiting entry.
- R3: A load packet (type code 0) issues exactly one program memory operation with op code 0 (allocate), carrying the packet's name, context and payload. A granted response (pm_rsp_hit=1) ends the packet with no output.
- R4: A load that is refused (pm_rsp_hit=0) is forwarded unchanged to the output.
- R5: A request packet (type code 1) issues a lookup (op code 1). A hit with pm_rsp_is_value=1 produces one output packet of type code 2 that has the request's name and context and carries pm_rsp_value as its payload.
- R6: A lookup hit on an expression (pm_rsp_is_value=0) writes one waiting entry holding the request's name, context and payload.
- R7: After that waiting entry, if pm_rsp_requested=0, the block emits one request packet (type 1) for each identifier, pm_rsp_id_cnt of them, taken in index order 0 upward from pm_rsp_ids. Identifier i sits in bits [8i+7:8i]. Each new request keeps the context and carries the zero-extended name of the original object as its payload. If pm_rsp_requested=1, or the count is 0, no request is emitted.
- R8: A result packet (type code 2) makes exactly one program memory access with op code 2 (update), carrying the name, context and payload. It waits for no response and produces no output.
- R9: A lookup that misses (pm_rsp_hit=0) forwards the request unchanged to the output.
- R10: out_port is always (out_name XOR out_ctx) mod 4, which is out_name[1:0] XOR out_ctx[1:0].
- R11: While a valid on out, ws or pm_req is held low by its ready, the fields on that channel do not change.
- R12: The block works on one packet at a time. in_ready stays 0 from the moment a packet is accepted until the last output of that packet has been taken. At most one of out_valid, ws_valid and pm_req_valid is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input queue has a packet |
| in_ready | output | 1 | Dispatcher accepts the packet |
| in_transit | input | 1 | Packet is only passing through this node |
| in_type | input | 2 | 0 load, 1 request, 2 result, 3 reserved |
| in_name | input | 8 | Object name |
| in_ctx | input | 4 | Object context |
| in_data | input | 32 | Payload |
| pm_req_valid | output | 1 | Program memory operation valid |
| pm_req_ready | input | 1 | Program memory takes the operation |
| pm_req_op | output | 2 | 0 allocate, 1 lookup, 2 update |
| pm_req_name | output | 8 | Operation name |
| pm_req_ctx | output | 4 | Operation context |
| pm_req_data | output | 32 | Operation payload |
| pm_rsp_valid | input | 1 | Program memory response valid |
| pm_rsp_hit | input | 1 | Found (lookup) or granted (allocate) |
| pm_rsp_is_value | input | 1 | Entry found is a reduced value |
| pm_rsp_requested | input | 1 | Expression was already requested |
| pm_rsp_value | input | 32 | Value found |
| pm_rsp_id_cnt | input | 3 | Number of identifiers in the expression |
| pm_rsp_ids | input | 32 | Up to four identifier names |
| ws_valid | output | 1 | Waiting entry valid |
| ws_ready | input | 1 | Waiting store takes the entry |
| ws_name | output | 8 | Name awaited |
| ws_ctx | output | 4 | Context awaited |
| ws_data | output | 32 | Requester payload |
| out_valid | output | 1 | Output packet valid |
| out_ready | input | 1 | Output queue takes the packet |
| out_type | output | 2 | Output packet type |
| out_name | output | 8 | Output packet name |
| out_ctx | output | 4 | Output packet context |
| out_data | output | 32 | Output packet payload |
| out_port | output | 2 | Output sub-queue selected |

## Verification
A wrong state or a stale packet register shows up on the first channel that the packet drives. That is the op code or fields of the next program memory operation, or the type, name and payload of the next output or waiting entry. It appears within two cycles of the handshake that caused it. A fan-out index or count that is off shows up as a missing, repeated or reordered identifier request. A dispatcher that does not go back to idle shows up as in_ready staying low. Stall cases are checked by holding each ready low. During the stall the fields must stay put and the input must stay blocked.

// File: rtl/reduce_pkg.sv
package reduce_pkg;
  typedef enum logic [1:0] {
    PK_LOAD = 2'd0,
    PK_REQ  = 2'd1,
    PK_RES  = 2'd2,
    PK_RSV  = 2'd3
  } pk_type_e;

  typedef enum logic [1:0] {
    PM_ALLOC  = 2'd0,
    PM_LOOKUP = 2'd1,
    PM_UPDATE = 2'd2
  } pm_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PMREQ,
    ST_PMWAIT,
    ST_SEND,
    ST_PARK,
    ST_FAN
  } disp_state_e;
endpackage

// File: rtl/reduce_hash.sv
module reduce_hash #(
  parameter int PORT_W = 2
) (
  input  logic [PORT_W-1:0] key_name,
  input  logic [PORT_W-1:0] key_ctx,
  output logic [PORT_W-1:0] port
);
  // low bits of name XOR context give the successor sub-queue
  always_comb port = key_name ^ key_ctx;
endmodule

// File: rtl/reduce_id_pick.sv
module reduce_id_pick #(
  parameter int NAME_W  = 8,
  parameter int MAX_IDS = 4,
  localparam int IDX_W  = $clog2(MAX_IDS)
) (
  input  logic [MAX_IDS*NAME_W-1:0] ids,
  input  logic [IDX_W-1:0]          idx,
  output logic [NAME_W-1:0]         id
);
  always_comb begin
    id = '0;
    for (int i = 0; i < MAX_IDS; i++) begin
      if (idx == IDX_W'(i)) id = ids[i*NAME_W +: NAME_W];
    end
  end
endmodule

// File: rtl/reduce_dispatch.sv
module reduce_dispatch
  import reduce_pkg::*;
#(
  parameter int NAME_W  = 8,
  parameter int CTX_W   = 4,
  parameter int DATA_W  = 32,
  parameter int PORTS   = 4,
  parameter int MAX_IDS = 4,
  localparam int PORT_W = $clog2(PORTS),
  localparam int IDX_W  = $clog2(MAX_IDS),
  localparam int CNT_W  = $clog2(MAX_IDS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_transit,
  input  logic [1:0]                in_type,
  input  logic [NAME_W-1:0]         in_name,
  input  logic [CTX_W-1:0]          in_ctx,
  input  logic [DATA_W-1:0]         in_data,
  output logic                      pm_req_valid,
  input  logic                      pm_req_ready,
  output logic [1:0]                pm_req_op,
  output logic [NAME_W-1:0]         pm_req_name,
  output logic [CTX_W-1:0]          pm_req_ctx,
  output logic [DATA_W-1:0]         pm_req_data,
  input  logic                      pm_rsp_valid,
  input  logic                      pm_rsp_hit,
  input  logic                      pm_rsp_is_value,
  input  logic                      pm_rsp_requested,
  input  logic [DATA_W-1:0]         pm_rsp_value,
  input  logic [CNT_W-1:0]          pm_rsp_id_cnt,
  input  logic [MAX_IDS*NAME_W-1:0] pm_rsp_ids,
  output logic                      ws_valid,
  input  logic                      ws_ready,
  output logic [NAME_W-1:0]         ws_name,
  output logic [CTX_W-1:0]          ws_ctx,
  output logic [DATA_W-1:0]         ws_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [1:0]                out_type,
  output logic [NAME_W-1:0]         out_name,
  output logic [CTX_W-1:0]          out_ctx,
  output logic [DATA_W-1:0]         out_data,
  output logic [PORT_W-1:0]         out_port
);

  disp_state_e state_q, state_d;

  logic [1:0]                type_q;
  logic [NAME_W-1:0]         name_q;
  logic [CTX_W-1:0]          ctx_q;
  logic [DATA_W-1:0]         data_q;
  logic [DATA_W-1:0]         val_q;
  logic                      res_q, res_d;
  logic                      fan_q, fan_d;
  logic [CNT_W-1:0]          cnt_q;
  logic [IDX_W-1:0]          idx_q, idx_d;
  logic [MAX_IDS*NAME_W-1:0] ids_q;
  logic [NAME_W-1:0]         fan_id;
  logic [CNT_W-1:0]          cnt_clamp;

  logic pkt_en, rsp_take, idx_en;

  assign pkt_en   = in_valid && in_ready;
  assign rsp_take = (state_q == ST_PMWAIT) && pm_rsp_valid;
  assign cnt_clamp = (pm_rsp_id_cnt > CNT_W'(MAX_IDS)) ? CNT_W'(MAX_IDS) : pm_rsp_id_cnt;

  // next-state logic
  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    fan_d   = fan_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          res_d = 1'b0;
          if (in_transit || in_type == PK_RSV) state_d = ST_SEND;
          else                                 state_d = ST_PMREQ;
        end
      end
      ST_PMREQ: begin
        if (pm_req_ready) state_d = (type_q == PK_RES) ? ST_IDLE : ST_PMWAIT;
      end
      ST_PMWAIT: begin
        if (pm_rsp_valid) begin
          if (type_q == PK_LOAD) begin
            state_d = pm_rsp_hit ? ST_IDLE : ST_SEND;
          end else if (!pm_rsp_hit) begin
            state_d = ST_SEND;
          end else if (pm_rsp_is_value) begin
            res_d   = 1'b1;
            state_d = ST_SEND;
          end else begin
            fan_d   = !pm_rsp_requested && (cnt_clamp != '0);
            state_d = ST_PARK;
          end
        end
      end
      ST_SEND: begin
        if (out_ready) state_d = ST_IDLE;
      end
      ST_PARK: begin
        if (ws_ready) begin
          idx_d   = '0;
          idx_en  = 1'b1;
          state_d = fan_q ? ST_FAN : ST_IDLE;
        end
      end
      ST_FAN: begin
        if (out_ready) begin
          if (CNT_W'(idx_q) + CNT_W'(1) == cnt_q) begin
            state_d = ST_IDLE;
          end else begin
            idx_d  = idx_q + IDX_W'(1);
            idx_en = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state and control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      res_q   <= 1'b0;
      fan_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      fan_q   <= fan_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  // packet and response holding registers, written only on handshakes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      name_q <= '0;
      ctx_q  <= '0;
      data_q <= '0;
      val_q  <= '0;
      cnt_q  <= '0;
      ids_q  <= '0;
    end else begin
      if (pkt_en) begin
        type_q <= in_type;
        name_q <= in_name;
        ctx_q  <= in_ctx;
        data_q <= in_data;
      end
      if (rsp_take) begin
        val_q <= pm_rsp_value;
        cnt_q <= cnt_clamp;
        ids_q <= pm_rsp_ids;
      end
    end
  end

  reduce_id_pick #(.NAME_W(NAME_W), .MAX_IDS(MAX_IDS)) id_pick_i (
    .ids (ids_q),
    .idx (idx_q),
    .id  (fan_id)
  );

  reduce_hash #(.PORT_W(PORT_W)) hash_i (
    .key_name (out_name[PORT_W-1:0]),
    .key_ctx  (out_ctx[PORT_W-1:0]),
    .port     (out_port)
  );

  // channel drive
  always_comb begin
    in_ready     = (state_q == ST_IDLE);
    pm_req_valid = (state_q == ST_PMREQ);
    unique case (type_q)
      PK_LOAD: pm_req_op = PM_ALLOC;
      PK_REQ:  pm_req_op = PM_LOOKUP;
      default: pm_req_op = PM_UPDATE;
    endcase
    pm_req_name = name_q;
    pm_req_ctx  = ctx_q;
    pm_req_data = data_q;
    ws_valid    = (state_q == ST_PARK);
    ws_name     = name_q;
    ws_ctx      = ctx_q;
    ws_data     = data_q;
    out_valid   = (state_q == ST_SEND) || (state_q == ST_FAN);
    out_ctx     = ctx_q;
    if (state_q == ST_FAN) begin
      out_type = PK_REQ;
      out_name = fan_id;
      out_data = {{(DATA_W-NAME_W){1'b0}}, name_q};
    end else if (res_q) begin
      out_type = PK_RES;
      out_name = name_q;
      out_data = val_q;
    end else begin
      out_type = type_q;
      out_name = name_q;
      out_data = data_q;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> in_ready && !out_valid && !pm_req_valid && !ws_valid);

  // R12
  one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({out_valid, pm_req_valid, ws_valid}) <= 1);

  // R12
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || pm_req_valid || ws_valid) |-> !in_ready);

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_name) && $stable(out_type) && $stable(out_data) && $stable(out_ctx));

  // R11
  pm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_req_valid && !pm_req_ready |=> pm_req_valid && $stable(pm_req_op) && $stable(pm_req_name) && $stable(pm_req_data));

  // R8
  update_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_req_valid && pm_req_ready && pm_req_op == 2'd2 |=> in_ready);

  // R10
  port_hash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_port == (out_name[1:0] ^ out_ctx[1:0]));

endmodule

// File: tb/reduce_dispatch_tb.sv
module reduce_dispatch_tb_top;
  logic        clk, rst_n;
  logic        in_valid, in_ready, in_transit;
  logic [1:0]  in_type;
  logic [7:0]  in_name;
  logic [3:0]  in_ctx;
  logic [31:0] in_data;
  logic        pm_req_valid, pm_req_ready;
  logic [1:0]  pm_req_op;
  logic [7:0]  pm_req_name;
  logic [3:0]  pm_req_ctx;
  logic [31:0] pm_req_data;
  logic        pm_rsp_valid, pm_rsp_hit, pm_rsp_is_value, pm_rsp_requested;
  logic [31:0] pm_rsp_value;
  logic [2:0]  pm_rsp_id_cnt;
  logic [31:0] pm_rsp_ids;
  logic        ws_valid, ws_ready;
  logic [7:0]  ws_name;
  logic [3:0]  ws_ctx;
  logic [31:0] ws_data;
  logic        out_valid, out_ready;
  logic [1:0]  out_type;
  logic [7:0]  out_name;
  logic [3:0]  out_ctx;
  logic [31:0] out_data;
  logic [1:0]  out_port;

  int n_chk = 0, n_bad = 0;
  int out_cnt = 0, pm_cnt = 0, ws_cnt = 0;

  reduce_dispatch dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) out_cnt++;
      if (pm_req_valid && pm_req_ready) pm_cnt++;
      if (ws_valid && ws_ready) ws_cnt++;
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] hp(logic [7:0] n, logic [3:0] c);
    return n[1:0] ^ c[1:0];
  endfunction

  task automatic send_pkt(logic tr, logic [1:0] ty, logic [7:0] nm, logic [3:0] cx, logic [31:0] dt);
    int k;
    in_transit = tr; in_type = ty; in_name = nm; in_ctx = cx; in_data = dt;
    in_valid = 1'b1;
    k = 0;
    while (!in_ready && k < 50) begin @(negedge clk); k++; end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic get_pm(string req, logic [1:0] op, logic [7:0] nm, logic [3:0] cx, logic [31:0] dt);
    int k;
    k = 0;
    while (!pm_req_valid && k < 50) begin @(negedge clk); k++; end
    chk(req, "pm valid", pm_req_valid, 1);
    chk(req, "pm op", pm_req_op, op);
    chk(req, "pm name", pm_req_name, nm);
    chk(req, "pm ctx", pm_req_ctx, cx);
    chk(req, "pm data", pm_req_data, dt);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic give_rsp(logic hit, logic isv, logic rq, logic [31:0] v, logic [2:0] n, logic [31:0] ids);
    pm_rsp_hit = hit; pm_rsp_is_value = isv; pm_rsp_requested = rq;
    pm_rsp_value = v; pm_rsp_id_cnt = n; pm_rsp_ids = ids;
    pm_rsp_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pm_rsp_valid = 1'b0;
  endtask

  task automatic get_out(string req, logic [1:0] ty, logic [7:0] nm, logic [3:0] cx, logic [31:0] dt, int stall);
    int k;
    k = 0;
    if (stall > 0) out_ready = 1'b0;
    while (!out_valid && k < 50) begin @(negedge clk); k++; end
    chk(req, "out valid", out_valid, 1);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R11", "held out name", out_name, nm);
      chk("R12", "in_ready during stall", in_ready, 0);
    end
    out_ready = 1'b1;
    chk(req, "out type", out_type, ty);
    chk(req, "out name", out_name, nm);
    chk(req, "out ctx", out_ctx, cx);
    chk(req, "out data", out_data, dt);
    chk("R10", "out port", out_port, hp(nm, cx));
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic get_ws(string req, logic [7:0] nm, logic [3:0] cx, logic [31:0] dt);
    int k;
    k = 0;
    while (!ws_valid && k < 50) begin @(negedge clk); k++; end
    chk(req, "ws valid", ws_valid, 1);
    chk(req, "ws name", ws_name, nm);
    chk(req, "ws ctx", ws_ctx, cx);
    chk(req, "ws data", ws_data, dt);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle(string req, int o0, int p0, int w0, int o_exp, int p_exp, int w_exp);
    repeat (4) @(negedge clk);
    chk(req, "back to idle", in_ready, 1);
    chk(req, "outputs emitted", out_cnt - o0, o_exp);
    chk(req, "pm accesses", pm_cnt - p0, p_exp);
    chk(req, "waiting entries", ws_cnt - w0, w_exp);
  endtask

  task automatic t_reset;
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "pm_req_valid", pm_req_valid, 0);
    chk("R1", "ws_valid", ws_valid, 0);
  endtask

  task automatic t_transit;
    int o0 = out_cnt, p0 = pm_cnt, w0 = ws_cnt;
    send_pkt(1'b1, 2'd0, 8'h5A, 4'h3, 32'hDEADBEEF);
    get_out("R2", 2'd0, 8'h5A, 4'h3, 32'hDEADBEEF, 0);
    send_pkt(1'b0, 2'd3, 8'h0E, 4'h9, 32'h00C0FFEE);
    get_out("R2", 2'd3, 8'h0E, 4'h9, 32'h00C0FFEE, 0);
    settle("R2", o0, p0, w0, 2, 0, 0);
  endtask

  task automatic t_load_ok;
    int o0 = out_cnt, p0 = pm_cnt, w0 = ws_cnt;
    send_pkt(1'b0, 2'd0, 8'h21, 4'h2, 32'h00001234);
    get_pm("R3", 2'd0, 8'h21, 4'h2, 32'h00001234);
    give_rsp(1'b1, 1'b0, 1'b0, 32'h0, 3'd0, 32'h0);
    settle("R3", o0, p0, w0, 0, 1, 0);
  endtask

  task automatic t_load_clash;
    int o0 = out_cnt, p0 = pm_cnt, w0 = ws_cnt;
    send_pkt(1'b0, 2'd0, 8'h21, 4'h2, 32'h00005678);
    get_pm("R4", 2'd0, 8'h21, 4'h2, 32'h00005678);
    give_rsp(1'b0, 1'b0, 1'b0, 32'h0, 3'd0, 32'h0);
    get_out("R4", 2'd0, 8'h21, 4'h2, 32'h00005678, 0);
    settle("R4", o0, p0, w0, 1, 1, 0);
  endtask

  task automatic t_req_value;
    int o0 = out_cnt, p0 = pm_cnt, w0 = ws_cnt;
    send_pkt(1'b0, 2'd1, 8'h33, 4'h1, 32'h00000077);
    get_pm("R5", 2'd1, 8'h33, 4'h1, 32'h00000077);
    give_rsp(1'b1, 1'b1, 1'b0, 32'hCAFE0001, 3'd2, 32'h0000_4142);
    get_out("R5", 2'd2, 8'h33, 4'h1, 32'hCAFE0001, 2);
    settle("R5", o0, p0, w0, 1, 1, 0);
  endtask

  task automatic t_req_miss;
    int o0 = out_cnt, p0 = pm_cnt, w0 = ws_cnt;
    send_pkt(1'b0, 2'd1, 8'h40, 4'hF, 32'h0BADF00D);
    get_pm("R9", 2'd1, 8'h40, 4'hF, 32'h0BADF00D);
    give_rsp(1'b0, 1'b0, 1'b0, 32'h11111111, 3'd0, 32'h0);
    get_out("R9", 2'd1, 8'h40, 4'hF, 32'h0BADF00D, 0);
    settle("R9", o0, p0, w0, 1, 1, 0);
  endtask

  task automatic t_expr_fan;
    int o0 = out_cnt, p0 = pm_cnt, w0 = ws_cnt;
    send_pkt(1'b0, 2'd1, 8'h66, 4'h6, 32'h00000099);
    get_pm("R6", 2'd1, 8'h66, 4'h6, 32'h00000099);
    give_rsp(1'b1, 1'b0, 1'b0, 32'h0, 3'd3, 32'hAA12_1110);
    get_ws("R6", 8'h66, 4'h6, 32'h00000099);
    get_out("R7", 2'd1, 8'h10, 4'h6, 32'h00000066, 0);
    get_out("R7", 2'd1, 8'h11, 4'h6, 32'h00000066, 3);
    get_out("R7", 2'd1, 8'h12, 4'h6, 32'h00000066, 0);
    settle("R7", o0, p0, w0, 3, 1, 1);
  endtask

  task automatic t_expr_max;
    int o0 = out_cnt, p0 = pm_cnt, w0 = ws_cnt;
    send_pkt(1'b0, 2'd1, 8'h07, 4'hD, 32'h00000001);
    get_pm("R7", 2'd1, 8'h07, 4'hD, 32'h00000001);
    give_rsp(1'b1, 1'b0, 1'b0, 32'h0, 3'd4, 32'h8382_8180);
    get_ws("R6", 8'h07, 4'hD, 32'h00000001);
    for (int i = 0; i < 4; i++)
      get_out("R7", 2'd1, 8'h80 + 8'(i), 4'hD, 32'h00000007, 0);
    settle("R7", o0, p0, w0, 4, 1, 1);
  endtask

  task automatic t_expr_quiet;
    int o0 = out_cnt, p0 = pm_cnt, w0 = ws_cnt;
    send_pkt(1'b0, 2'd1, 8'h2B, 4'h4, 32'h00000005);
    get_pm("R6", 2'd1, 8'h2B, 4'h4, 32'h00000005);
    give_rsp(1'b1, 1'b0, 1'b1, 32'h0, 3'd2, 32'h0000_5150);
    get_ws("R6", 8'h2B, 4'h4, 32'h00000005);
    settle("R7", o0, p0, w0, 0, 1, 1);
    o0 = out_cnt; p0 = pm_cnt; w0 = ws_cnt;
    send_pkt(1'b0, 2'd1, 8'h2C, 4'h4, 32'h00000006);
    get_pm("R6", 2'd1, 8'h2C, 4'h4, 32'h00000006);
    give_rsp(1'b1, 1'b0, 1'b0, 32'h0, 3'd0, 32'h0);
    get_ws("R6", 8'h2C, 4'h4, 32'h00000006);
    settle("R7", o0, p0, w0, 0, 1, 1);
  endtask

  task automatic t_result;
    int o0 = out_cnt, p0 = pm_cnt, w0 = ws_cnt;
    send_pkt(1'b0, 2'd2, 8'h55, 4'h5, 32'h0000ABCD);
    pm_req_ready = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R11", "pm valid held", pm_req_valid, 1);
      chk("R12", "in_ready blocked", in_ready, 0);
    end
    pm_req_ready = 1'b1;
    get_pm("R8", 2'd2, 8'h55, 4'h5, 32'h0000ABCD);
    chk("R8", "idle right after update", in_ready, 1);
    settle("R8", o0, p0, w0, 0, 1, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 0; in_transit = 0; in_type = 0; in_name = 0; in_ctx = 0; in_data = 0;
    pm_req_ready = 1; pm_rsp_valid = 0; pm_rsp_hit = 0; pm_rsp_is_value = 0;
    pm_rsp_requested = 0; pm_rsp_value = 0; pm_rsp_id_cnt = 0; pm_rsp_ids = 0;
    ws_ready = 1; out_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_transit();
    t_load_ok();
    t_load_clash();
    t_req_value();
    t_req_miss();
    t_expr_fan();
    t_expr_max();
    t_expr_quiet();
    t_result();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule